// File: doc/BRIEF.md
# DMA Channel Transfer Sequencer

This block is one DMA channel engine. Once a block transfer has been programmed through its load port, it waits for a request. It then moves data one transfer unit at a time over a single-master memory bus. After each unit it steps its source and destination addresses and lowers its remaining count. When the count runs out it raises a done flag and stops issuing bus cycles. A unit is a byte, a halfword, a word, or a 16-byte burst. A burst is carried as four word reads into an internal buffer, followed by four word writes.

There are three addressing schemes:

- **Dual direct:** the engine reads at the source address and writes at the destination address.
- **Dual indirect:** the source register points at a 32-bit pointer. The pointer is fetched as two halfword reads, and the data is then read from the address it holds.
- **Single:** one side of the transfer is a peripheral that an acknowledge strobe selects, so a unit needs only one bus cycle per beat.

An optional reload returns the source address to its programmed start after every fourth unit. A configuration bit chooses whether the external request line or the internal peripheral request line starts units.

The state machine has seven states: `ST_IDLE`, `ST_ARMED`, `ST_PTR_HI`, `ST_PTR_LO`, `ST_READ`, `ST_WRITE` and `ST_SINGLE`. Its transitions are:

- `ST_IDLE` goes to `ST_ARMED` on an accepted load.
- `ST_ARMED` goes to the first state of a unit when the selected request is high and no load is present. That first state is `ST_PTR_HI` in indirect mode, `ST_SINGLE` in single mode, and `ST_READ` otherwise.
- `ST_PTR_HI` goes to `ST_PTR_LO`, and `ST_PTR_LO` goes to `ST_READ`, each on ready.
- `ST_READ` stays put on ready until its last beat, then goes to `ST_WRITE`.
- `ST_WRITE` and `ST_SINGLE` stay put on ready until their last beat. At the unit boundary they go:
  - to `ST_IDLE` if that was the last unit;
  - to the first state of the next unit if the request is still high;
  - to `ST_ARMED` otherwise.

Top module: `xc_chan`

## Requirements
- R1: After reset, bus_req, bus_ack and done are low, and no bus cycle is issued until a block has been loaded and a request is seen.
- R2: cfg_req_sel = 0 makes ext_req the only request source and cfg_req_sel = 1 makes per_req the only one; the unselected line starts nothing.
- R3: With cfg_amode = 0 (dual direct), each unit is one read at the source address followed by one write at the destination address. The write data equals the word returned by the read. bus_size codes are 0 byte, 1 halfword and 2 word, and cfg_size uses the same codes.
- R4: cfg_size = 3 (16-byte unit) issues four word reads at base, base+4, base+8 and base+12, then four word writes at the same offsets in the same order, carrying the four read words.
- R5: With cfg_amode = 1 (indirect), each unit first reads halfwords at src and src+2. bus_rdata[15:0] of the first read gives the pointer's upper 16 bits and that of the second read gives the lower 16 bits. The unit then reads at the pointer and writes to dst. The source register steps by 4 per unit.
- R6: With cfg_amode = 2 (single), each beat is one bus cycle with bus_ack high. cfg_to_periph = 1 makes it a read at src. cfg_to_periph = 0 makes it a write at dst with bus_wdata = 0.
- R7: Address mode codes are 0 fixed, 1 increment, 2 decrement and 3 fixed. The step per unit is 1, 2, 4 or 16 bytes for size codes 0 to 3 (indirect source: 4).
- R8: cfg_count is 24 bits and 0 means 16777216 units. done rises with the last unit's final ready and no further bus cycle follows. A new load clears done.
- R9: With cfg_reload = 1, the source address returns to its loaded start value after every 4th completed unit.
- R10: bus_req, bus_addr, bus_we and bus_size hold steady until a one-cycle bus_rdy completes the cycle, whatever the number of wait cycles.
- R11: A request is taken only in the armed state or at a unit boundary. If the request is low at a boundary, the engine waits with no bus activity.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| cfg_load | input | 1 | Load pulse; accepted only when no unit is in flight |
| cfg_src | input | AW | Source start address (pointer location in indirect mode) |
| cfg_dst | input | AW | Destination start address |
| cfg_count | input | CW | Units in the block, 0 means 2^CW |
| cfg_size | input | 2 | Unit size code |
| cfg_amode | input | 2 | 0 dual direct, 1 dual indirect, 2 single |
| cfg_src_mode | input | 2 | Source address mode |
| cfg_dst_mode | input | 2 | Destination address mode |
| cfg_reload | input | 1 | Enable source reload every 4 units |
| cfg_req_sel | input | 1 | 0 external request, 1 peripheral request |
| cfg_to_periph | input | 1 | Single mode direction: 1 memory to peripheral |
| ext_req | input | 1 | External transfer request (level) |
| per_req | input | 1 | Internal peripheral request (level) |
| bus_ack | output | 1 | Acknowledge strobe selecting the peripheral in single mode |
| bus_req | output | 1 | Bus cycle request |
| bus_we | output | 1 | Bus cycle is a write |
| bus_size | output | 2 | Bus cycle size code |
| bus_addr | output | AW | Bus address |
| bus_wdata | output | DW | Write data, right aligned |
| bus_rdata | input | DW | Read data, right aligned |
| bus_rdy | input | 1 | One-cycle completion of the current bus cycle |
| done | output | 1 | Block complete |

## Verification
The bench goes after the following corner cases:

- **Burst buffer:** beat order across a 16-byte unit. A buffer indexed wrongly writes the words shuffled or repeats one.
- **Pointer assembly:** how the indirect pointer is built from two halfword reads. Swapped halves send the data read to the wrong address.
- **Source reload:** the reload point on the fourth unit. Off by one, the source sequence repeats too early or too late.
- **Unit boundary:** a request dropped between units. A design that does not recheck the request keeps running.
- **Request select:** the wrong line would start the block.
- **Zero count:** a count of zero must not be treated as an empty block.

Random wait states on the bus show whether any bus signal moves before ready.

// File: rtl/xc_pkg.sv
package xc_pkg;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_ARMED,
        ST_PTR_HI,
        ST_PTR_LO,
        ST_READ,
        ST_WRITE,
        ST_SINGLE
    } xc_state_e;

    localparam logic [1:0] SZ_BYTE  = 2'd0;
    localparam logic [1:0] SZ_HALF  = 2'd1;
    localparam logic [1:0] SZ_WORD  = 2'd2;
    localparam logic [1:0] SZ_BURST = 2'd3;

    localparam logic [1:0] AM_DIRECT   = 2'd0;
    localparam logic [1:0] AM_INDIRECT = 2'd1;
    localparam logic [1:0] AM_SINGLE   = 2'd2;

    localparam logic [1:0] AD_FIXED = 2'd0;
    localparam logic [1:0] AD_INC   = 2'd1;
    localparam logic [1:0] AD_DEC   = 2'd2;

endpackage

// File: rtl/xc_fsm.sv
module xc_fsm
    import xc_pkg::*;
#(
    parameter int BEATS = 4,
    parameter int BW    = $clog2(BEATS)
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            load,
    input  logic            req,
    input  logic            rdy,
    input  logic            last_unit,
    input  logic [1:0]      size,
    input  logic [1:0]      amode,
    output xc_state_e       state,
    output logic [BW-1:0]   beat,
    output logic            busy,
    output logic            unit_done,
    output logic            cap_hi,
    output logic            cap_lo,
    output logic            cap_data
);

    xc_state_e     nxt;
    xc_state_e     first_st;
    logic [BW-1:0] beat_nxt;
    logic          last_beat;

    always_comb begin
        last_beat = (size == SZ_BURST) ? (beat == BW'(BEATS - 1)) : 1'b1;
        if (amode == AM_INDIRECT)
            first_st = ST_PTR_HI;
        else if (amode == AM_SINGLE)
            first_st = ST_SINGLE;
        else
            first_st = ST_READ;
    end

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state <= ST_IDLE;
            beat  <= '0;
        end else begin
            state <= nxt;
            beat  <= beat_nxt;
        end
    end

    // next state
    always_comb begin
        nxt      = state;
        beat_nxt = beat;
        unique case (state)
            ST_IDLE:   if (load) nxt = ST_ARMED;
            ST_ARMED:  if (req && !load) nxt = first_st;
            ST_PTR_HI: if (rdy) nxt = ST_PTR_LO;
            ST_PTR_LO: if (rdy) nxt = ST_READ;
            ST_READ: begin
                if (rdy) begin
                    if (last_beat) begin
                        nxt      = ST_WRITE;
                        beat_nxt = '0;
                    end else begin
                        beat_nxt = beat + BW'(1);
                    end
                end
            end
            ST_WRITE, ST_SINGLE: begin
                if (rdy) begin
                    if (last_beat) begin
                        beat_nxt = '0;
                        if (last_unit)
                            nxt = ST_IDLE;
                        else if (req)
                            nxt = first_st;
                        else
                            nxt = ST_ARMED;
                    end else begin
                        beat_nxt = beat + BW'(1);
                    end
                end
            end
            default: nxt = ST_IDLE;
        endcase
    end

    // outputs
    always_comb begin
        busy      = (state != ST_IDLE) && (state != ST_ARMED);
        unit_done = rdy && last_beat && ((state == ST_WRITE) || (state == ST_SINGLE));
        cap_hi    = rdy && (state == ST_PTR_HI);
        cap_lo    = rdy && (state == ST_PTR_LO);
        cap_data  = rdy && (state == ST_READ);
    end

endmodule

// File: rtl/xc_count.sv
module xc_count #(
    parameter int CW = 24
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          load,
    input  logic [CW-1:0] ld_cnt,
    input  logic          unit_done,
    output logic          last_unit,
    output logic          done
);

    logic [CW:0] rem;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            rem  <= '0;
            done <= 1'b0;
        end else if (load) begin
            rem  <= (ld_cnt == '0) ? {1'b1, {CW{1'b0}}} : {1'b0, ld_cnt};
            done <= 1'b0;
        end else if (unit_done) begin
            rem <= rem - (CW+1)'(1);
            if (rem == (CW+1)'(1))
                done <= 1'b1;
        end
    end

    assign last_unit = (rem == (CW+1)'(1));

endmodule

// File: rtl/xc_addr.sv
module xc_addr
    import xc_pkg::*;
#(
    parameter int AW     = 32,
    parameter int RELOAD = 4,
    parameter int RW     = $clog2(RELOAD)
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          load,
    input  logic [AW-1:0] ld_src,
    input  logic [AW-1:0] ld_dst,
    input  logic [1:0]    smode,
    input  logic [1:0]    dmode,
    input  logic [4:0]    sstep,
    input  logic [4:0]    dstep,
    input  logic          reload_en,
    input  logic          unit_done,
    output logic [AW-1:0] src,
    output logic [AW-1:0] dst
);

    logic [AW-1:0] start_q;
    logic [RW-1:0] rl_cnt;

    function automatic logic [AW-1:0] adv(input logic [AW-1:0] a,
                                          input logic [1:0] mode,
                                          input logic [4:0] step);
        case (mode)
            AD_INC:  return a + AW'(step);
            AD_DEC:  return a - AW'(step);
            default: return a;
        endcase
    endfunction

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            start_q <= '0;
            src     <= '0;
            dst     <= '0;
            rl_cnt  <= '0;
        end else if (load) begin
            start_q <= ld_src;
            src     <= ld_src;
            dst     <= ld_dst;
            rl_cnt  <= '0;
        end else if (unit_done) begin
            rl_cnt <= rl_cnt + RW'(1);
            if (reload_en && (rl_cnt == RW'(RELOAD - 1)))
                src <= start_q;
            else
                src <= adv(src, smode, sstep);
            dst <= adv(dst, dmode, dstep);
        end
    end

endmodule

// File: rtl/xc_chan.sv
module xc_chan
    import xc_pkg::*;
#(
    parameter int AW    = 32,
    parameter int DW    = 32,
    parameter int CW    = 24,
    parameter int BEATS = 4
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          cfg_load,
    input  logic [AW-1:0] cfg_src,
    input  logic [AW-1:0] cfg_dst,
    input  logic [CW-1:0] cfg_count,
    input  logic [1:0]    cfg_size,
    input  logic [1:0]    cfg_amode,
    input  logic [1:0]    cfg_src_mode,
    input  logic [1:0]    cfg_dst_mode,
    input  logic          cfg_reload,
    input  logic          cfg_req_sel,
    input  logic          cfg_to_periph,
    input  logic          ext_req,
    input  logic          per_req,
    output logic          bus_ack,
    output logic          bus_req,
    output logic          bus_we,
    output logic [1:0]    bus_size,
    output logic [AW-1:0] bus_addr,
    output logic [DW-1:0] bus_wdata,
    input  logic [DW-1:0] bus_rdata,
    input  logic          bus_rdy,
    output logic          done
);

    localparam int BW = $clog2(BEATS);
    localparam int HW = AW / 2;

    xc_state_e     state;
    logic [BW-1:0] beat;
    logic          busy, unit_done, cap_hi, cap_lo, cap_data;
    logic          last_unit, load_ok, req;
    logic [1:0]    size_q, amode_q, smode_q, dmode_q;
    logic          reload_q, rsel_q, dir_q;
    logic [AW-1:0] src, dst, ptr_q, boff;
    logic [4:0]    ub, sstep;
    logic [DW-1:0] buf_q [BEATS];

    assign load_ok = cfg_load && !busy;
    assign req     = rsel_q ? per_req : ext_req;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            size_q   <= SZ_BYTE;
            amode_q  <= AM_DIRECT;
            smode_q  <= AD_FIXED;
            dmode_q  <= AD_FIXED;
            reload_q <= 1'b0;
            rsel_q   <= 1'b0;
            dir_q    <= 1'b0;
        end else if (load_ok) begin
            size_q   <= cfg_size;
            amode_q  <= cfg_amode;
            smode_q  <= cfg_src_mode;
            dmode_q  <= cfg_dst_mode;
            reload_q <= cfg_reload;
            rsel_q   <= cfg_req_sel;
            dir_q    <= cfg_to_periph;
        end
    end

    always_comb begin
        case (size_q)
            SZ_BYTE: ub = 5'd1;
            SZ_HALF: ub = 5'd2;
            SZ_WORD: ub = 5'd4;
            default: ub = 5'd16;
        endcase
        sstep = (amode_q == AM_INDIRECT) ? 5'd4 : ub;
    end

    xc_fsm #(.BEATS(BEATS), .BW(BW)) u_fsm (
        .clk       (clk),
        .rst_n     (rst_n),
        .load      (load_ok),
        .req       (req),
        .rdy       (bus_rdy),
        .last_unit (last_unit),
        .size      (size_q),
        .amode     (amode_q),
        .state     (state),
        .beat      (beat),
        .busy      (busy),
        .unit_done (unit_done),
        .cap_hi    (cap_hi),
        .cap_lo    (cap_lo),
        .cap_data  (cap_data)
    );

    xc_count #(.CW(CW)) u_cnt (
        .clk       (clk),
        .rst_n     (rst_n),
        .load      (load_ok),
        .ld_cnt    (cfg_count),
        .unit_done (unit_done),
        .last_unit (last_unit),
        .done      (done)
    );

    xc_addr #(.AW(AW), .RELOAD(4)) u_addr (
        .clk       (clk),
        .rst_n     (rst_n),
        .load      (load_ok),
        .ld_src    (cfg_src),
        .ld_dst    (cfg_dst),
        .smode     (smode_q),
        .dmode     (dmode_q),
        .sstep     (sstep),
        .dstep     (ub),
        .reload_en (reload_q),
        .unit_done (unit_done),
        .src       (src),
        .dst       (dst)
    );

    // pointer halves for indirect fetch
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)
            ptr_q <= '0;
        else if (cap_hi)
            ptr_q[AW-1:HW] <= bus_rdata[HW-1:0];
        else if (cap_lo)
            ptr_q[HW-1:0] <= bus_rdata[HW-1:0];
    end

    // burst buffer, one word per beat
    for (genvar g = 0; g < BEATS; g++) begin : g_buf
        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n)
                buf_q[g] <= '0;
            else if (cap_data && (beat == BW'(g)))
                buf_q[g] <= bus_rdata;
        end
    end

    assign boff = AW'(beat) << 2;

    always_comb begin
        bus_req   = busy;
        bus_we    = 1'b0;
        bus_ack   = 1'b0;
        bus_addr  = '0;
        bus_wdata = '0;
        bus_size  = (size_q == SZ_BURST) ? SZ_WORD : size_q;
        unique case (state)
            ST_PTR_HI: begin
                bus_addr = src;
                bus_size = SZ_HALF;
            end
            ST_PTR_LO: begin
                bus_addr = src + AW'(2);
                bus_size = SZ_HALF;
            end
            ST_READ:   bus_addr = ((amode_q == AM_INDIRECT) ? ptr_q : src) + boff;
            ST_WRITE: begin
                bus_we    = 1'b1;
                bus_addr  = dst + boff;
                bus_wdata = buf_q[beat];
            end
            ST_SINGLE: begin
                bus_ack  = 1'b1;
                bus_we   = !dir_q;
                bus_addr = (dir_q ? src : dst) + boff;
            end
            default: bus_size = SZ_BYTE;
        endcase
    end

endmodule

// File: rtl/xc_chan_chk.sv
module xc_chan_chk
    import xc_pkg::*;
#(
    parameter int AW = 32
) (
    input logic          clk,
    input logic          rst_n,
    input xc_state_e     state,
    input logic          bus_req,
    input logic          bus_rdy,
    input logic          bus_we,
    input logic          bus_ack,
    input logic [1:0]    bus_size,
    input logic [AW-1:0] bus_addr,
    input logic          done,
    input logic          unit_done,
    input logic [1:0]    size_q
);

    assert_hold_R10: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_req && !bus_rdy) |=> (bus_req && $stable(bus_addr) && $stable(bus_we) && $stable(bus_size)));

    assert_ack_single_R6: assert property (@(posedge clk) disable iff (!rst_n)
        bus_ack |-> (bus_req && state == ST_SINGLE));

    assert_done_quiet_R8: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> !bus_req);

    assert_done_after_unit_R8: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(done) |-> $past(unit_done));

    assert_ptr_half_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_PTR_HI || state == ST_PTR_LO) |-> (bus_size == SZ_HALF && !bus_we));

    assert_burst_word_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (size_q == SZ_BURST && (state == ST_READ || state == ST_WRITE)) |-> bus_size == SZ_WORD);

endmodule

bind xc_chan xc_chan_chk #(.AW(AW)) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .state     (state),
    .bus_req   (bus_req),
    .bus_rdy   (bus_rdy),
    .bus_we    (bus_we),
    .bus_ack   (bus_ack),
    .bus_size  (bus_size),
    .bus_addr  (bus_addr),
    .done      (done),
    .unit_done (unit_done),
    .size_q    (size_q)
);

// File: tb/sim_xc_chan.sv
module sim_xc_chan;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        cfg_load = 1'b0;
    logic [31:0] c_src = '0, c_dst = '0;
    logic [23:0] c_cnt = '0;
    logic [1:0]  c_size = '0, c_am = '0, c_sm = '0, c_dm = '0;
    logic        c_rl = 1'b0, c_sel = 1'b0, c_dir = 1'b0;
    logic        ext_req = 1'b0, per_req = 1'b0;
    logic        bus_ack, bus_req, bus_we, done;
    logic [1:0]  bus_size;
    logic [31:0] bus_addr, bus_wdata;
    logic [31:0] bus_rdata = '0;
    logic        bus_rdy = 1'b0;

    int checks = 0;
    int errors = 0;
    int cyc = 0;
    int wait_left = 0;

    logic [31:0] lg_addr [256];
    logic [31:0] lg_wd   [256];
    logic [1:0]  lg_size [256];
    logic        lg_we   [256];
    logic        lg_ack  [256];
    int          lg_n = 0;

    logic [31:0] ex_addr [256];
    logic [31:0] ex_wd   [256];
    logic [1:0]  ex_size [256];
    logic        ex_we   [256];
    logic        ex_ack  [256];
    int          ex_n = 0;

    always #5 clk = ~clk;

    xc_chan u0 (
        .clk(clk), .rst_n(rst_n), .cfg_load(cfg_load),
        .cfg_src(c_src), .cfg_dst(c_dst), .cfg_count(c_cnt),
        .cfg_size(c_size), .cfg_amode(c_am), .cfg_src_mode(c_sm),
        .cfg_dst_mode(c_dm), .cfg_reload(c_rl), .cfg_req_sel(c_sel),
        .cfg_to_periph(c_dir), .ext_req(ext_req), .per_req(per_req),
        .bus_ack(bus_ack), .bus_req(bus_req), .bus_we(bus_we),
        .bus_size(bus_size), .bus_addr(bus_addr), .bus_wdata(bus_wdata),
        .bus_rdata(bus_rdata), .bus_rdy(bus_rdy), .done(done)
    );

    function automatic logic [31:0] mem_f(input logic [31:0] a);
        return {~a[15:0], a[15:0] ^ 16'h9BDF};
    endfunction

    function automatic logic [31:0] stepf(input logic [31:0] a, input logic [1:0] m, input int s);
        if (m == 2'd1) return a + s;
        if (m == 2'd2) return a - s;
        return a;
    endfunction

    // bus responder with random wait states
    always @(negedge clk) begin
        if (bus_rdy) begin
            bus_rdy = 1'b0;
            wait_left = $urandom % 3;
        end else if (bus_req) begin
            if (wait_left == 0) begin
                bus_rdy   = 1'b1;
                bus_rdata = mem_f(bus_addr);
                if (lg_n < 256) begin
                    lg_addr[lg_n] = bus_addr;
                    lg_we[lg_n]   = bus_we;
                    lg_size[lg_n] = bus_size;
                    lg_ack[lg_n]  = bus_ack;
                    lg_wd[lg_n]   = bus_wdata;
                end
                lg_n++;
            end else begin
                wait_left--;
            end
        end
    end

    task automatic summary_and_end();
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    endtask

    always @(posedge clk) begin
        cyc++;
        if (cyc > 150000) begin
            errors++;
            $display("FAIL watchdog actual=%0d expected<150000", cyc);
            summary_and_end();
        end
    end

    task automatic chk(input bit ok, input string tag, input string what,
                       input logic [63:0] act, input logic [63:0] exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s %s actual=%0h expected=%0h", tag, what, act, exp);
        end
    endtask

    task automatic push(input logic [31:0] a, input logic we, input logic [1:0] sz,
                        input logic ack, input logic [31:0] wd);
        ex_addr[ex_n] = a; ex_we[ex_n] = we; ex_size[ex_n] = sz;
        ex_ack[ex_n] = ack; ex_wd[ex_n] = wd;
        ex_n++;
    endtask

    task automatic build_exp(input int n);
        logic [31:0] s, d, p, m1, m2;
        int nb, ubytes;
        logic [1:0] bs;
        s = c_src; d = c_dst; ex_n = 0;
        nb = (c_size == 2'd3) ? 4 : 1;
        bs = (c_size == 2'd3) ? 2'd2 : c_size;
        ubytes = (c_size == 2'd0) ? 1 : (c_size == 2'd1) ? 2 : (c_size == 2'd2) ? 4 : 16;
        for (int u = 0; u < n; u++) begin
            if (c_am == 2'd1) begin
                push(s, 0, 2'd1, 0, 0);
                push(s + 2, 0, 2'd1, 0, 0);
                m1 = mem_f(s); m2 = mem_f(s + 2);
                p = {m1[15:0], m2[15:0]};
                for (int b = 0; b < nb; b++) push(p + 4*b, 0, bs, 0, 0);
                for (int b = 0; b < nb; b++) push(d + 4*b, 1, bs, 0, mem_f(p + 4*b));
            end else if (c_am == 2'd2) begin
                for (int b = 0; b < nb; b++)
                    if (c_dir) push(s + 4*b, 0, bs, 1, 0);
                    else       push(d + 4*b, 1, bs, 1, 0);
            end else begin
                for (int b = 0; b < nb; b++) push(s + 4*b, 0, bs, 0, 0);
                for (int b = 0; b < nb; b++) push(d + 4*b, 1, bs, 0, mem_f(s + 4*b));
            end
            if (c_rl && (u % 4 == 3)) s = c_src;
            else s = stepf(s, c_sm, (c_am == 2'd1) ? 4 : ubytes);
            d = stepf(d, c_dm, ubytes);
        end
    endtask

    task automatic compare_log(input string tag);
        int bad;
        bad = -1;
        chk(lg_n == ex_n, tag, "bus cycle count", lg_n, ex_n);
        for (int i = 0; i < ex_n && i < lg_n; i++) begin
            if (bad < 0 && (lg_addr[i] !== ex_addr[i] || lg_we[i] !== ex_we[i] ||
                lg_size[i] !== ex_size[i] || lg_ack[i] !== ex_ack[i] ||
                (lg_we[i] && lg_wd[i] !== ex_wd[i])))
                bad = i;
        end
        if (bad < 0)
            chk(1'b1, tag, "bus sequence", 0, 0);
        else
            chk(1'b0, tag, $sformatf("cycle %0d {addr,we,size,ack} / wdata", bad),
                {lg_addr[bad], lg_we[bad], lg_size[bad], lg_ack[bad]},
                {ex_addr[bad], ex_we[bad], ex_size[bad], ex_ack[bad]});
        if (bad >= 0 && lg_we[bad])
            $display("  wdata actual=%0h expected=%0h", lg_wd[bad], ex_wd[bad]);
    endtask

    task automatic pulse_load();
        @(negedge clk);
        lg_n = 0;
        cfg_load = 1'b1;
        @(negedge clk);
        cfg_load = 1'b0;
        chk(done == 1'b0, "R8", "done cleared by load", done, 0);
    endtask

    task automatic run_block(input string tag);
        int t;
        pulse_load();
        if (c_sel) per_req = 1'b1; else ext_req = 1'b1;
        t = 0;
        while (!done && t < 4000) begin
            @(negedge clk);
            t++;
        end
        repeat (10) @(negedge clk);
        ext_req = 1'b0; per_req = 1'b0;
        build_exp(int'(c_cnt));
        compare_log(tag);
        chk(done && !bus_req, "R8", "done high and bus quiet", {done, bus_req}, 2'b10);
    endtask

    task automatic set_cfg(input logic [31:0] s, input logic [31:0] d, input int n,
                           input logic [1:0] sz, input logic [1:0] am, input logic [1:0] sm,
                           input logic [1:0] dm, input logic rl, input logic sel, input logic dir);
        c_src = s; c_dst = d; c_cnt = 24'(n); c_size = sz; c_am = am;
        c_sm = sm; c_dm = dm; c_rl = rl; c_sel = sel; c_dir = dir;
    endtask

    initial begin
        int n1;
        void'($urandom(32'd20251));
        repeat (5) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        chk(!bus_req && !bus_ack && !done, "R1", "reset outputs", {bus_req, bus_ack, done}, 0);
        ext_req = 1'b1; per_req = 1'b1;
        repeat (20) @(negedge clk);
        chk(lg_n == 0, "R1", "no cycles before load", lg_n, 0);
        ext_req = 1'b0; per_req = 1'b0;

        // R3 direct byte increment
        set_cfg(32'h0000_1000, 32'h0000_2000, 5, 2'd0, 2'd0, 2'd1, 2'd1, 0, 0, 0);
        run_block("R3");
        // R7 halfword, source decrement, destination fixed (R10 under waits)
        set_cfg(32'h0000_3010, 32'h0000_4000, 4, 2'd1, 2'd0, 2'd2, 2'd0, 0, 0, 0);
        run_block("R7/R10");
        // R3 word
        set_cfg(32'h0001_0000, 32'h0002_0000, 3, 2'd2, 2'd0, 2'd1, 2'd1, 0, 0, 0);
        run_block("R3");
        // R4 16-byte direct
        set_cfg(32'h0000_5000, 32'h0000_6000, 2, 2'd3, 2'd0, 2'd1, 2'd1, 0, 0, 0);
        run_block("R4");
        // R5 indirect word
        set_cfg(32'h0000_7000, 32'h0000_8000, 3, 2'd2, 2'd1, 2'd1, 2'd1, 0, 0, 0);
        run_block("R5");
        // R5 indirect 16-byte, decrementing pointer table
        set_cfg(32'h0000_7100, 32'h0000_9000, 2, 2'd3, 2'd1, 2'd2, 2'd1, 0, 0, 0);
        run_block("R5/R4");
        // R6 single, peripheral to memory
        set_cfg(32'h0, 32'h0000_A000, 4, 2'd1, 2'd2, 2'd0, 2'd1, 0, 0, 0);
        run_block("R6");
        // R6 single, memory to peripheral
        set_cfg(32'h0000_B000, 32'h0, 3, 2'd2, 2'd2, 2'd1, 2'd0, 0, 1, 1);
        run_block("R6");
        // R9 reload
        set_cfg(32'h0000_C000, 32'h0000_D000, 9, 2'd0, 2'd0, 2'd1, 2'd1, 1, 0, 0);
        run_block("R9");

        // R2 unselected line is ignored
        set_cfg(32'h0000_E000, 32'h0000_F000, 2, 2'd2, 2'd0, 2'd1, 2'd1, 0, 1, 0);
        pulse_load();
        ext_req = 1'b1;
        repeat (30) @(negedge clk);
        chk(lg_n == 0 && !bus_req, "R2", "external request ignored", lg_n, 0);
        ext_req = 1'b0;
        per_req = 1'b1;
        while (!done && cyc < 140000) @(negedge clk);
        per_req = 1'b0;
        build_exp(2);
        compare_log("R2");

        // R11 request dropped before the unit boundary
        set_cfg(32'h0001_1000, 32'h0001_2000, 3, 2'd2, 2'd0, 2'd1, 2'd1, 0, 0, 0);
        pulse_load();
        repeat (20) @(negedge clk);
        chk(lg_n == 0, "R11", "armed waits for request", lg_n, 0);
        ext_req = 1'b1;
        @(negedge clk);
        ext_req = 1'b0;
        repeat (40) @(negedge clk);
        chk(lg_n == 2 && !done && !bus_req, "R11", "one unit then wait", lg_n, 2);
        ext_req = 1'b1;
        while (!done && cyc < 140000) @(negedge clk);
        ext_req = 1'b0;
        build_exp(3);
        compare_log("R11");

        // R8 zero count means a full 2^24 block, not an empty one
        set_cfg(32'h0002_0000, 32'h0003_0000, 0, 2'd2, 2'd0, 2'd1, 2'd1, 0, 0, 0);
        pulse_load();
        ext_req = 1'b1;
        repeat (60) @(negedge clk);
        chk(!done && lg_n > 4, "R8", "zero count keeps running", {done, 31'(lg_n)}, 5);
        ext_req = 1'b0;
        repeat (30) @(negedge clk);
        n1 = lg_n;
        repeat (20) @(negedge clk);
        chk(lg_n == n1 && !bus_req, "R11", "stops at boundary", lg_n, n1);

        // random blocks
        for (int k = 0; k < 14; k++) begin
            logic [1:0] am, sz, sm, dm;
            am = 2'($urandom % 3);
            sz = 2'($urandom % 4);
            sm = 2'($urandom % 4);
            dm = 2'($urandom % 4);
            set_cfg($urandom, $urandom, 1 + ($urandom % 6), sz, am, sm, dm,
                    1'($urandom % 2), 1'($urandom % 2), 1'($urandom % 2));
            run_block("R3/R7/R9/R10 random");
        end

        summary_and_end();
    end

endmodule